// File: doc/BRIEF.md
# Serial ADC Lane Deserializer with Frame Alignment

This block turns serialized converter samples arriving on up to eight data lanes back into parallel words. All lanes share one double-data-rate bit clock and one frame clock that toggles at the sample rate. The capture cells at the pins are outside the block. They hand over, on every cycle of the fabric clock, the bit taken on the rising bit-clock edge and the bit taken on the falling edge for each lane and for the frame clock. The block treats the frame clock as one more data lane. A rising transition in it marks the first bit of a sample word.

Each channel either owns one lane (one-wire mode) or is split across a pair of lanes at half the bit rate (two-wire mode). The resolution is 12, 14 or 16 bits. A frame counter tracks how many bits have arrived since the last frame edge. When a word is complete, every channel's word is presented at once, right-justified in its own 16-bit field, together with a single valid pulse. A frame edge that is missing or that comes too early raises a sticky error flag. The resolution and lane mode are static and may only change while reset is held.

Top module: `serial_adc_deser`

## Requirements
- R1: While and after reset, before any word completes, `wordValid` and `frameErr` are low and every field of `chanWords` is zero.
- R2: In one-wire mode (`twoWire`=0), lane c carries channel c most significant bit first, N bits per word (N=12 for `resSel`=0, 14 for 1, 16 for 2). The word appears right-justified in field c, `chanWords[16c+15:16c]`, with the bits above N zero.
- R3: In two-wire mode, channel c (c<4) is rebuilt from lane 2c and lane 2c+1, each lane carrying N/2 bits per word. Lane 2c carries word bits N-1, N-3, ..., 1 and lane 2c+1 carries bits N-2, N-4, ..., 0, highest first on both lanes. Fields 4 to 7 read zero.
- R4: Each cycle, every lane and the frame input supply two serial bits, the rise bit first and the fall bit second. A word boundary may fall on either of the two positions.
- R5: A frame bit of 1 whose preceding frame bit is 0 marks bit 0 of a word. The words and a one-cycle `wordValid` pulse appear after the clock edge that takes in bit L-1, where L is N in one-wire mode and N/2 in two-wire mode.
- R6: After reset, no word is presented until the first rising frame transition has been seen.
- R7: If bit index L arrives without a rising frame transition, `frameErr` is set and stays set until reset. Output stops until the next rising frame transition, and capture resumes from there.
- R8: A rising frame transition at a bit index below L, after alignment, sets `frameErr`. The partial word is dropped and counting restarts at that transition.
- R9: `wordValid` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock, one per bit-clock period |
| rst | input | 1 | Synchronous active-high reset |
| twoWire | input | 1 | 0: one lane per channel, 1: two lanes per channel |
| resSel | input | 2 | Resolution: 0 = 12, 1 = 14, 2 = 16 bits |
| laneRise | input | NUM_LANES | Bit of each lane taken on the rising bit-clock edge |
| laneFall | input | NUM_LANES | Bit of each lane taken on the falling bit-clock edge |
| frameRise | input | 1 | Frame clock taken on the rising bit-clock edge |
| frameFall | input | 1 | Frame clock taken on the falling bit-clock edge |
| wordValid | output | 1 | One-cycle pulse when all channel words are updated |
| chanWords | output | NUM_LANES*16 | Channel words, field c at bits 16c+15:16c |
| frameErr | output | 1 | Sticky frame alignment error |

## Verification
The hardest situations to reach from the ports are the ones where the word length is odd per lane, as with two-wire 14-bit (7 bits per lane). There the word boundary alternates between the rise and fall positions from one frame to the next. Frame-clock faults are also hard to reach. The stimulus builds whole serial bit streams in the bench from random sample words, with random-length idle preambles that shift the alignment by single bits. Directed streams then drop one frame edge entirely or insert a spurious extra edge late in a word. In those cases the bench expects the affected word to vanish, the next one to come out intact and the error flag to stay set.

// File: rtl/sad_pkg.sv
package sad_pkg;
  localparam int CNT_W = 5;

  typedef struct packed {
    logic             wordDone;
    logic             endAtRise;
    logic [CNT_W-1:0] laneBits;
    logic [CNT_W-1:0] resBits;
  } strobe_t;

  function automatic logic [CNT_W-1:0] resOf(input logic [1:0] sel);
    case (sel)
      2'd0:    return CNT_W'(12);
      2'd1:    return CNT_W'(14);
      default: return CNT_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/sad_frame_ctrl.sv
module sad_frame_ctrl
  import sad_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        twoWire,
  input  logic [1:0]  resSel,
  input  logic        frameRise,
  input  logic        frameFall,
  output strobe_t     stb,
  output logic        frameErr
);
  logic [CNT_W-1:0] resBits, laneBits;
  logic             fPrev, synced;
  logic [CNT_W-1:0] cnt;

  logic             e0, e1, err0, err1, done0, done1, sync0, sync1;
  logic [CNT_W-1:0] idx0, idx1, cnt0, cnt1;

  assign resBits  = resOf(resSel);
  assign laneBits = twoWire ? (resBits >> 1) : resBits;

  always_comb begin
    e0 = frameRise & ~fPrev;
    e1 = frameFall & ~frameRise;
    err0 = 1'b0;
    err1 = 1'b0;
    // first (rise) slot
    sync0 = synced;
    idx0  = cnt;
    if (e0) begin
      if (synced && cnt != laneBits) err0 = 1'b1;
      sync0 = 1'b1;
      idx0  = '0;
    end else if (synced && cnt == laneBits) begin
      err0  = 1'b1;
      sync0 = 1'b0;
    end
    done0 = sync0 && (idx0 == laneBits - CNT_W'(1));
    cnt0  = idx0 + CNT_W'(1);
    // second (fall) slot
    sync1 = sync0;
    idx1  = cnt0;
    if (e1) begin
      if (sync0 && cnt0 != laneBits) err1 = 1'b1;
      sync1 = 1'b1;
      idx1  = '0;
    end else if (sync0 && cnt0 == laneBits) begin
      err1  = 1'b1;
      sync1 = 1'b0;
    end
    done1 = sync1 && (idx1 == laneBits - CNT_W'(1));
    cnt1  = idx1 + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fPrev    <= 1'b0;
      synced   <= 1'b0;
      cnt      <= '0;
      frameErr <= 1'b0;
    end else begin
      fPrev  <= frameFall;
      synced <= sync1;
      cnt    <= cnt1;
      if (err0 || err1) frameErr <= 1'b1;
    end
  end

  assign stb.wordDone  = done0 | done1;
  assign stb.endAtRise = done0;
  assign stb.laneBits  = laneBits;
  assign stb.resBits   = resBits;

  // R7: once raised the error flag holds until reset
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
    frameErr |=> frameErr);

  // R8: an aligned stream seeing an edge before the word is full flags an error
  a_r8_early_edge_flag: assert property (@(posedge clk) disable iff (rst)
    (synced && frameRise && !fPrev && cnt != laneBits) |=> frameErr);

  // R5: while aligned the bit count never passes the lane word length
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    synced |-> (cnt <= laneBits));
endmodule

// File: rtl/sad_lane_path.sv
module sad_lane_path
  import sad_pkg::*;
#(
  parameter int NUM_LANES = 8,
  parameter int FIELD_W   = 16
)(
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         twoWire,
  input  strobe_t                      stb,
  input  logic [NUM_LANES-1:0]         laneRise,
  input  logic [NUM_LANES-1:0]         laneFall,
  output logic                         wordValid,
  output logic [NUM_LANES*FIELD_W-1:0] chanWords
);
  localparam int HIST_W = FIELD_W + 2;
  localparam int HALF_W = FIELD_W / 2;
  localparam int NUM_PAIRS = NUM_LANES / 2;

  logic [HIST_W-1:0]  hist     [NUM_LANES];
  logic [HIST_W-1:0]  histNext [NUM_LANES];
  logic [FIELD_W-1:0] laneWord [NUM_LANES];
  logic [FIELD_W-1:0] fieldNext[NUM_LANES];
  logic [FIELD_W-1:0] laneMask;

  assign laneMask = (FIELD_W'(1) << stb.laneBits) - FIELD_W'(1);

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [HIST_W-1:0] aligned;
    assign histNext[l] = {hist[l][HIST_W-3:0], laneRise[l], laneFall[l]};
    assign aligned     = stb.endAtRise ? (histNext[l] >> 1) : histNext[l];
    assign laneWord[l] = aligned[FIELD_W-1:0] & laneMask;

    always_ff @(posedge clk) begin
      if (rst) hist[l] <= '0;
      else     hist[l] <= histNext[l];
    end
  end

  for (genvar c = 0; c < NUM_LANES; c++) begin : g_chan
    if (c < NUM_PAIRS) begin : g_pair
      logic [FIELD_W-1:0] woven;
      always_comb begin
        woven = '0;
        for (int j = 0; j < HALF_W; j++) begin
          woven[2*j+1] = laneWord[2*c][j];
          woven[2*j]   = laneWord[2*c+1][j];
        end
      end
      assign fieldNext[c] = twoWire ? woven : laneWord[c];
    end else begin : g_solo
      assign fieldNext[c] = twoWire ? '0 : laneWord[c];
    end

    always_ff @(posedge clk) begin
      if (rst)               chanWords[c*FIELD_W +: FIELD_W] <= '0;
      else if (stb.wordDone) chanWords[c*FIELD_W +: FIELD_W] <= fieldNext[c];
    end

    // R2: every field stays right-justified to the resolution
    a_r2_justified: assert property (@(posedge clk) disable iff (rst)
      wordValid |-> ((chanWords[c*FIELD_W +: FIELD_W] >> stb.resBits) == '0));

    if (c >= NUM_PAIRS) begin : g_upper
      // R3: lanes are paired, so upper fields carry nothing in two-wire mode
      a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (wordValid && twoWire) |-> (chanWords[c*FIELD_W +: FIELD_W] == '0));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) wordValid <= 1'b0;
    else     wordValid <= stb.wordDone;
  end

  // R9: one pulse per frame, never back to back
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    wordValid |=> !wordValid);
endmodule

// File: rtl/serial_adc_deser.sv
module serial_adc_deser
  import sad_pkg::*;
#(
  parameter int NUM_LANES = 8,
  parameter int FIELD_W   = 16
)(
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         twoWire,
  input  logic [1:0]                   resSel,
  input  logic [NUM_LANES-1:0]         laneRise,
  input  logic [NUM_LANES-1:0]         laneFall,
  input  logic                         frameRise,
  input  logic                         frameFall,
  output logic                         wordValid,
  output logic [NUM_LANES*FIELD_W-1:0] chanWords,
  output logic                         frameErr
);
  strobe_t stb;

  sad_frame_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .twoWire  (twoWire),
    .resSel   (resSel),
    .frameRise(frameRise),
    .frameFall(frameFall),
    .stb      (stb),
    .frameErr (frameErr)
  );

  sad_lane_path #(.NUM_LANES(NUM_LANES), .FIELD_W(FIELD_W)) u_path (
    .clk      (clk),
    .rst      (rst),
    .twoWire  (twoWire),
    .stb      (stb),
    .laneRise (laneRise),
    .laneFall (laneFall),
    .wordValid(wordValid),
    .chanWords(chanWords)
  );
endmodule

// File: tb/sim_serial_adc_deser.sv
module sim_serial_adc_deser;
  localparam int NL   = 8;
  localparam int MAXB = 1024;
  localparam int NFR  = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          twoWire = 1'b0;
  logic [1:0]    resSel = 2'd0;
  logic [NL-1:0] laneRise = '0, laneFall = '0;
  logic          frameRise = 1'b0, frameFall = 1'b0;
  logic          wordValid, frameErr;
  logic [NL*16-1:0] chanWords;

  serial_adc_deser u0 (.*);

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [NL-1:0] laneStr [MAXB];
  logic          frmStr  [MAXB];
  logic [15:0]   wd      [NFR+1][NL];
  int            endCyc  [NFR+1];
  bit            dropped [NFR+1];
  int            resN, laneL;

  function automatic int resFromSel(input logic [1:0] s);
    return (s == 2'd0) ? 12 : (s == 2'd1) ? 14 : 16;
  endfunction

  function automatic logic [15:0] expField(input int f, input int c);
    if (!twoWire) return wd[f][c];
    if (c < NL/2) return wd[f][c];
    return 16'h0;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [127:0] got, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic doReset(input bit tw, input logic [1:0] rs);
    rst = 1'b1;
    twoWire = tw;
    resSel = rs;
    laneRise = '0; laneFall = '0; frameRise = 1'b0; frameFall = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic genStream(input int pre, input int skipF, input int glitchF);
    resN  = resFromSel(resSel);
    laneL = twoWire ? resN/2 : resN;
    for (int t = 0; t < MAXB; t++) begin
      laneStr[t] = NL'($urandom);
      frmStr[t]  = 1'b0;
    end
    for (int f = 0; f <= NFR; f++) begin
      for (int c = 0; c < NL; c++) wd[f][c] = 16'($urandom) & 16'((1 << resN) - 1);
      endCyc[f]  = (pre + f*laneL + laneL - 1) / 2;
      dropped[f] = (f == skipF) || (f == glitchF);
      for (int k = 0; k < laneL; k++) begin
        int t = pre + f*laneL + k;
        frmStr[t] = (k < (laneL + 1)/2) && (f != skipF);
        if (f == glitchF && k == laneL - 2) frmStr[t] = 1'b1;
        for (int l = 0; l < NL; l++) begin
          if (!twoWire) laneStr[t][l] = wd[f][l][resN-1-k];
          else if (l % 2 == 0) laneStr[t][l] = wd[f][l/2][resN-1-2*k];
          else laneStr[t][l] = wd[f][l/2][resN-2-2*k];
        end
      end
    end
  endtask

  task automatic runStream(input string tag, input bit expErr);
    int last = endCyc[NFR-1];
    for (int i = 0; i <= last; i++) begin
      int ef = -1;
      @(negedge clk);
      laneRise  = laneStr[2*i];
      laneFall  = laneStr[2*i+1];
      frameRise = frmStr[2*i];
      frameFall = frmStr[2*i+1];
      @(posedge clk);
      #1;
      for (int f = 0; f < NFR; f++)
        if (endCyc[f] == i && !dropped[f]) ef = f;
      if (ef >= 0) begin
        logic [NL*16-1:0] exp;
        for (int c = 0; c < NL; c++) exp[c*16 +: 16] = expField(ef, c);
        check(wordValid == 1'b1, {tag, " R5 valid at word end"}, 128'(wordValid), 128'(1));
        check(chanWords == exp, {tag, " R5 word"}, chanWords, exp);
      end else if (wordValid) begin
        check(1'b0, {tag, " R6/R9 spurious valid"}, 128'(wordValid), 128'(0));
      end
    end
    check(frameErr == expErr, {tag, expErr ? " R7/R8 error flag" : " R7 no error"},
          128'(frameErr), 128'(expErr));
  endtask

  initial begin
    #(4*200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired got hang exp finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R1: reset state
    doReset(1'b0, 2'd0);
    @(posedge clk); #1;
    check(!wordValid && !frameErr && chanWords == '0, "R1 reset state",
          {chanWords[125:0], wordValid, frameErr}, 128'(0));

    // R2 / R3 / R4: random words in every mode and resolution, random alignment
    for (int tw = 0; tw < 2; tw++) begin
      for (int rs = 0; rs < 3; rs++) begin
        for (int rep = 0; rep < 2; rep++) begin
          doReset(1'(tw), 2'(rs));
          genStream(int'($urandom_range(0, 7)), -1, -1);
          runStream(tw ? "R3/R4 two-wire" : "R2/R4 one-wire", 1'b0);
        end
      end
    end

    // R4: odd lane length with odd preamble, boundary alternates rise/fall
    doReset(1'b1, 2'd1);
    genStream(1, -1, -1);
    runStream("R4 two-wire 14b odd offset", 1'b0);

    // R6: long idle preamble with random data, nothing before first edge
    doReset(1'b0, 2'd2);
    genStream(9, -1, -1);
    runStream("R6 long preamble", 1'b0);

    // R7: one frame edge missing
    doReset(1'b0, 2'd0);
    genStream(3, 4, -1);
    runStream("R7 missing edge", 1'b1);

    // R8: spurious early edge inside a word
    doReset(1'b1, 2'd2);
    genStream(2, -1, 5);
    runStream("R8 early edge", 1'b1);

    // R7: the flag stays up with no further stimulus until reset
    @(negedge clk); laneRise = '0; laneFall = '0; frameRise = 1'b0; frameFall = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    check(frameErr == 1'b1, "R7 sticky", 128'(frameErr), 128'(1));

    // R1: reset clears the error
    doReset(1'b1, 2'd2);
    @(posedge clk); #1;
    check(!frameErr && !wordValid, "R1 reset clears", 128'({frameErr, wordValid}), 128'(0));

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule